// File: doc/BRIEF.md
# Context-Relative Address Redirection Unit

This unit sits in the data address path between a 16-bit processor and its data memory. A small window at the very top of the byte address space holds per-context scratch storage. In user mode, a direct-addressed access that lands in this window is moved to a frame just below a per-context base pointer, so switching context needs only a new pointer value and no copying of the scratch storage. In interrupt mode the same window keeps its literal address. Those accesses are marked so that a separate internal-RAM mapping can serve them.

Each request carries a byte address, an addressing class (direct, indirect, indexed), the processor mode, a byte/word size flag and the user-mode base pointer. The unit returns the physical address, an alternate-translator select, the unchanged size flag and a base-alignment error. These pass through one registered stage with a valid/ready handshake. Ready passes combinationally from downstream to upstream.

Top module: `ctxmap_unit`

## Requirements
- R1: The window is byte addresses 0xFFC0..0xFFFF inclusive. Address 0xFFBF is outside the window and 0xFFC0 is inside it.
- R2: In user mode (user_mode_i=1), a direct access (kind_i=0) inside the window maps to base_i plus the address read as a signed 16-bit value. So 0xFFC0 becomes base-64 and 0xFFFF becomes base-1.
- R3: An indirect access (kind_i=1), an indexed access (kind_i=2) or a reserved-class access (kind_i=3) is never redirected, even inside the window.
- R4: In interrupt mode (user_mode_i=0), a direct access inside the window keeps its literal address.
- R5: alt_xlat_o is 1 exactly for an interrupt-mode direct access inside the window, and 0 otherwise.
- R6: The redirected sum wraps modulo 2^16. For example, base 0x0010 with address 0xFFC0 gives 0xFFD0.
- R7: An address outside the window passes through unchanged in every mode and every class.
- R8: The output stage loads only when out_ready_i=1. out_valid_o then follows in_valid_i one cycle later. While out_ready_i=0, out_valid_o and all data outputs hold. in_ready_o equals out_ready_i combinationally. After reset, out_valid_o=0.
- R9: The size flag (is_byte_i=1 for a byte access) reaches is_byte_o unchanged.
- R10: base_err_o is 1 exactly when an access is redirected and base_i is odd.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| in_valid_i | input | 1 | Request valid |
| in_ready_o | output | 1 | Request accepted (follows out_ready_i) |
| addr_i | input | 16 | Requested byte address |
| kind_i | input | 2 | Addressing class: 0 direct, 1 indirect, 2 indexed, 3 reserved |
| user_mode_i | input | 1 | 1 user mode, 0 interrupt mode |
| is_byte_i | input | 1 | 1 byte access, 0 word access |
| base_i | input | 16 | User-mode base pointer |
| out_valid_o | output | 1 | Result valid |
| out_ready_i | input | 1 | Downstream ready |
| phys_addr_o | output | 16 | Resulting byte address |
| alt_xlat_o | output | 1 | Select the alternate internal-RAM translator |
| is_byte_o | output | 1 | Size flag carried through |
| base_err_o | output | 1 | Redirect used an odd base |

## Verification
Two functions can meet in the same cycle: a redirected window access and the wrap of its sum past zero. In that cycle the base-alignment error and the address arithmetic must also agree. This case is forced by directed requests with small and odd base values at the window edges, and random stimulus hits it again and again. A second overlap is a window access arriving while downstream stalls, which must leave the held result untouched. A behavioural model in the bench computes each expected output from the requirements and compares it with the outputs on every clock.

// File: rtl/ctxmap_pkg.sv
package ctxmap_pkg;
  parameter int unsigned ADDR_W    = 16;
  parameter int unsigned WIN_BYTES = 64;
  localparam int unsigned WIN_BITS = $clog2(WIN_BYTES);

  typedef enum logic [1:0] {
    KIND_DIRECT   = 2'd0,
    KIND_INDIRECT = 2'd1,
    KIND_INDEXED  = 2'd2,
    KIND_RSVD     = 2'd3
  } acc_kind_e;

  typedef struct packed {
    logic [ADDR_W-1:0] phys;
    logic              alt;
    logic              is_byte;
    logic              err;
  } xlat_res_t;
endpackage

// File: rtl/ctxmap_window_detect.sv
module ctxmap_window_detect
  import ctxmap_pkg::*;
(
  input  logic [ADDR_W-1:0] addr_i,
  output logic              hit_o
);
  // window is the top WIN_BYTES of the byte space
  assign hit_o = &addr_i[ADDR_W-1:WIN_BITS];

  always_comb begin
    if (addr_i == {ADDR_W{1'b1}})
      AST_TOP_IN_WINDOW: assert (hit_o); // R1
  end
endmodule

// File: rtl/ctxmap_relocate.sv
module ctxmap_relocate
  import ctxmap_pkg::*;
(
  input  logic [ADDR_W-1:0] addr_i,
  input  acc_kind_e         kind_i,
  input  logic              user_mode_i,
  input  logic              is_byte_i,
  input  logic [ADDR_W-1:0] base_i,
  input  logic              hit_i,
  output xlat_res_t         res_o
);
  logic direct;
  logic redirect;

  assign direct   = (kind_i == KIND_DIRECT);
  assign redirect = hit_i && direct && user_mode_i;

  always_comb begin
    res_o.phys    = addr_i;
    res_o.alt     = hit_i && direct && !user_mode_i;
    res_o.is_byte = is_byte_i;
    res_o.err     = redirect && base_i[0];
    // signed window offset added to base; wraps mod 2^ADDR_W
    if (redirect) res_o.phys = base_i + addr_i;
  end

  always_comb begin
    if (!hit_i)
      AST_OUTSIDE_LITERAL: assert (res_o.phys == addr_i && !res_o.alt && !res_o.err); // R7
  end
endmodule

// File: rtl/ctxmap_out_stage.sv
module ctxmap_out_stage #(
  parameter int unsigned W = 8
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         in_valid_i,
  output logic         in_ready_o,
  input  logic [W-1:0] in_data_i,
  output logic         out_valid_o,
  input  logic         out_ready_i,
  output logic [W-1:0] out_data_o
);
  assign in_ready_o = out_ready_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      out_valid_o <= 1'b0;
      out_data_o  <= '0;
    end else if (out_ready_i) begin
      out_valid_o <= in_valid_i;
      if (in_valid_i) out_data_o <= in_data_i;
    end
  end

  AST_STALL_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !out_ready_i |=> $stable(out_valid_o) && $stable(out_data_o)); // R8
  AST_VALID_FOLLOW: assert property (@(posedge clk_i) disable iff (!rst_ni)
    out_ready_i |=> out_valid_o == $past(in_valid_i)); // R8
endmodule

// File: rtl/ctxmap_unit.sv
module ctxmap_unit
  import ctxmap_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              in_valid_i,
  output logic              in_ready_o,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [1:0]        kind_i,
  input  logic              user_mode_i,
  input  logic              is_byte_i,
  input  logic [ADDR_W-1:0] base_i,
  output logic              out_valid_o,
  input  logic              out_ready_i,
  output logic [ADDR_W-1:0] phys_addr_o,
  output logic              alt_xlat_o,
  output logic              is_byte_o,
  output logic              base_err_o
);
  localparam int unsigned RES_W = $bits(xlat_res_t);

  logic      hit;
  xlat_res_t res_d, res_q;
  logic [RES_W-1:0] res_q_bits;

  ctxmap_window_detect u_win (
    .addr_i (addr_i),
    .hit_o  (hit)
  );

  ctxmap_relocate u_reloc (
    .addr_i      (addr_i),
    .kind_i      (acc_kind_e'(kind_i)),
    .user_mode_i (user_mode_i),
    .is_byte_i   (is_byte_i),
    .base_i      (base_i),
    .hit_i       (hit),
    .res_o       (res_d)
  );

  ctxmap_out_stage #(.W(RES_W)) u_stage (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .in_valid_i  (in_valid_i),
    .in_ready_o  (in_ready_o),
    .in_data_i   (res_d),
    .out_valid_o (out_valid_o),
    .out_ready_i (out_ready_i),
    .out_data_o  (res_q_bits)
  );

  assign res_q       = xlat_res_t'(res_q_bits);
  assign phys_addr_o = res_q.phys;
  assign alt_xlat_o  = res_q.alt;
  assign is_byte_o   = res_q.is_byte;
  assign base_err_o  = res_q.err;

  logic fire;
  logic win_in;
  assign fire   = in_valid_i && out_ready_i;
  assign win_in = (addr_i >= 16'hFFC0);

  AST_USER_REDIRECT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fire && win_in && user_mode_i && kind_i == 2'd0
    |=> phys_addr_o == $past(base_i) + $past(addr_i)); // R2
  AST_NONDIRECT_LITERAL: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fire && kind_i != 2'd0 |=> phys_addr_o == $past(addr_i) && !alt_xlat_o); // R3
  AST_IRQ_ALT_SELECT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fire && win_in && !user_mode_i && kind_i == 2'd0
    |=> alt_xlat_o && phys_addr_o == $past(addr_i)); // R5
  AST_SIZE_KEPT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fire |=> is_byte_o == $past(is_byte_i)); // R9
  AST_ERR_ONLY_ODD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fire |=> base_err_o == ($past(win_in && user_mode_i && kind_i == 2'd0) && $past(base_i[0]))); // R10
endmodule

// File: tb/ctxmap_unit_test.sv
`timescale 1ns/1ps
module ctxmap_unit_test;
  logic clk = 1'b0;
  logic rst_ni = 1'b0;
  logic in_valid = 1'b0, out_ready = 1'b0, user = 1'b0, is_byte = 1'b0;
  logic [15:0] addr = '0, base = '0;
  logic [1:0] kind = '0;
  logic in_ready, out_valid, alt, byte_o, err;
  logic [15:0] phys;

  int n_chk = 0, n_fail = 0;
  bit done = 0;

  always #10 clk = ~clk;

  ctxmap_unit uut (
    .clk_i(clk), .rst_ni(rst_ni), .in_valid_i(in_valid), .in_ready_o(in_ready),
    .addr_i(addr), .kind_i(kind), .user_mode_i(user), .is_byte_i(is_byte),
    .base_i(base), .out_valid_o(out_valid), .out_ready_i(out_ready),
    .phys_addr_o(phys), .alt_xlat_o(alt), .is_byte_o(byte_o), .base_err_o(err)
  );

  // reference model
  logic        m_valid = 0, m_alt = 0, m_byte = 0, m_err = 0;
  logic [15:0] m_phys = '0;
  string       m_tag = "R7";

  always @(posedge clk or negedge rst_ni) begin
    if (!rst_ni) begin
      m_valid <= 0; m_phys <= '0; m_alt <= 0; m_byte <= 0; m_err <= 0;
    end else if (out_ready) begin
      m_valid <= in_valid;
      if (in_valid) begin
        bit in_win, redir;
        int sum;
        in_win = (addr >= 16'hFFC0);
        redir  = in_win && user && kind == 2'd0;
        sum    = int'(base) + int'(addr) - 65536;
        m_phys <= redir ? 16'(sum) : addr;
        m_alt  <= in_win && !user && kind == 2'd0;
        m_byte <= is_byte;
        m_err  <= redir && base[0];
        if (addr == 16'hFFBF || addr == 16'hFFC0) m_tag <= "R1";
        else if (redir && sum < 0) m_tag <= "R6";
        else if (redir) m_tag <= "R2";
        else if (in_win && kind != 2'd0) m_tag <= "R3";
        else if (in_win) m_tag <= "R4";
        else m_tag <= "R7";
      end
    end
  end

  task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", tag, act, exp, $time);
    end
  endtask

  task automatic compare();
    chk("R8", 32'(out_valid), 32'(m_valid));
    if (m_valid) begin
      chk(m_tag, 32'(phys), 32'(m_phys));
      chk("R5", 32'(alt), 32'(m_alt));
      chk("R9", 32'(byte_o), 32'(m_byte));
      chk("R10", 32'(err), 32'(m_err));
    end
  endtask

  task automatic step(input logic v, input logic [15:0] a, input logic [1:0] k,
                      input logic u, input logic b, input logic [15:0] bs, input logic r);
    in_valid = v; addr = a; kind = k; user = u; is_byte = b; base = bs; out_ready = r;
    #1 chk("R8", 32'(in_ready), 32'(r));
    @(negedge clk);
    compare();
  endtask

  initial begin
    #(20 * 200000);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog expired");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    chk("R8", 32'(out_valid), 32'd0); // reset state
    rst_ni = 1'b1;
    @(negedge clk);
    step(1, 16'hFFC0, 2'd0, 1, 0, 16'h1000, 1); // R1 R2 -> 0x0FC0
    step(1, 16'hFFFF, 2'd0, 1, 0, 16'h1000, 1); // R2 -> 0x0FFF
    step(1, 16'hFFBF, 2'd0, 1, 0, 16'h1000, 1); // R1 outside
    step(1, 16'hFFC4, 2'd1, 1, 0, 16'h1000, 1); // R3 indirect
    step(1, 16'hFFC4, 2'd2, 1, 1, 16'h1000, 1); // R3 indexed, R9
    step(1, 16'hFFD0, 2'd0, 0, 0, 16'h1000, 1); // R4 R5
    step(1, 16'hFFC0, 2'd0, 1, 0, 16'h0010, 1); // R6 -> 0xFFD0
    step(1, 16'hFFE0, 2'd0, 1, 1, 16'h1001, 1); // R10 odd base
    step(1, 16'h1234, 2'd0, 0, 0, 16'h1001, 1); // R7
    step(1, 16'hFFF0, 2'd0, 1, 0, 16'h0001, 0); // R8 stall, holds
    step(1, 16'h0000, 2'd3, 1, 0, 16'h0001, 0); // R8 stall
    step(0, 16'hFFF0, 2'd0, 1, 0, 16'h2000, 1); // R8 bubble
    step(1, 16'hFFC8, 2'd0, 0, 1, 16'h2000, 1);
    for (int i = 0; i < 3000; i++) begin
      logic [15:0] a;
      a = $urandom_range(0, 3) != 0 ? (16'hFFC0 | 16'($urandom_range(0, 63)))
                                    : 16'($urandom);
      step(1'($urandom), a, 2'($urandom), 1'($urandom), 1'($urandom),
           16'($urandom_range(0, 200)), $urandom_range(0, 3) != 0);
    end
    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule